// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This unit takes two 128-bit source vectors and a 128-bit accumulator vector, each seen as four 32-bit lanes. Within a lane, each of the four bytes of the first source is multiplied by the byte at the same position in the second source. The four products are added together, and that sum is added to the matching accumulator lane. A two-bit mode picks how each source byte is extended (sign or zero). A saturate flag picks between 32-bit wraparound and clamping of the final accumulate.

An operation is presented with a one-cycle `in_valid` pulse. One clock later the unit returns the 128-bit result with a one-cycle `out_valid` pulse. Between operations the result register keeps its last value. The unit does no decoding, has no memory port and handles only the 128-bit vector length.

Top module: `dot8_acc_unit`

## Requirements
- R1: Lane n (n = 0..3) occupies bits [32n+31:32n] of every vector. Its four products use bytes 4n, 4n+1, 4n+2 and 4n+3 of both sources, and byte k of `src_a` is always paired with byte k of `src_b`. Lanes do not affect one another.
- R2: `mode` is encoded as follows: 2'b00 = unsigned×unsigned, 2'b01 = unsigned×signed, 2'b10 = signed×signed, 2'b11 = signed×unsigned. The first named operand is `src_a` and the second is `src_b`.
- R3: In signed×signed mode, both bytes are sign-extended before they are multiplied.
- R4: In signed×unsigned mode, the `src_a` byte is sign-extended and the `src_b` byte is zero-extended.
- R5: In unsigned×signed mode, the `src_a` byte is zero-extended and the `src_b` byte is sign-extended.
- R6: In unsigned×unsigned mode, both bytes are zero-extended and the accumulator lane is treated as unsigned.
- R7: With `sat_en` = 0, the result lane equals the low 32 bits of (accumulator lane + sum of the four products).
- R8: With `sat_en` = 1 in modes 01, 10 and 11, the accumulator lane is read as signed. The exact sum is clamped to the range -2^31 to 2^31-1, so it saturates to 0x7FFFFFFF or 0x80000000.
- R9: With `sat_en` = 1 in mode 00, the accumulator lane is read as unsigned. The exact sum is clamped to at most 0xFFFFFFFF.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `result` is updated in that same cycle. When `in_valid` is low, `result` holds its value.
- R11: While `rst_n` is low at a clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| src_a | input | 128 | First byte-source vector |
| src_b | input | 128 | Second byte-source vector |
| acc_in | input | 128 | Accumulator vector, four 32-bit lanes |
| mode | input | 2 | Signedness selection (see R2) |
| sat_en | input | 1 | 1 = saturating accumulate, 0 = wraparound |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Accumulated result vector |

## Verification
Each of the 256 byte values is swept against a fixed set of eight partner bytes: 0x00, 0x01, 0x7F, 0x80, 0x81, 0xFE, 0xFF and 0x55. The sweep runs in every mode with and without saturation, and the bytes are rotated through all lane and byte positions. Because 0x80 and 0xFF change meaning between sign and zero extension, this sweep tells the four extension modes apart and catches any mispairing of bytes or lanes. A second pass fills every byte with 0x80 or 0xFF and sets the accumulator to 0x7FFFFFFF, 0x80000000 or 0xFFFFFFFF. That pass drives each clamp bound and each wraparound crossing, and it shows whether the accumulator is read as signed or unsigned in each mode. The pseudo-random contents of the other lanes show whether one lane leaks into another.

// File: rtl/dot8_pkg.sv
// Shared types for the packed byte dot-product accumulator.
// Assumes mode codes follow the operand-prefix order used by the issuing decoder.
package dot8_pkg;

    typedef enum logic [1:0] {
        DOT_UU = 2'b00,   // both operands zero-extended, unsigned accumulate
        DOT_US = 2'b01,   // first zero-extended, second sign-extended
        DOT_SS = 2'b10,   // both sign-extended
        DOT_SU = 2'b11    // first sign-extended, second zero-extended
    } dot_mode_e;

    // True when the first source byte is sign-extended
    function automatic logic first_signed(dot_mode_e m);
        return (m == DOT_SS) || (m == DOT_SU);
    endfunction

    // True when the second source byte is sign-extended
    function automatic logic second_signed(dot_mode_e m);
        return (m == DOT_SS) || (m == DOT_US);
    endfunction

    // True when the accumulator lane is read as signed
    function automatic logic acc_signed(dot_mode_e m);
        return m != DOT_UU;
    endfunction

endpackage

// File: rtl/dot8_byte_mul.sv
// One byte-pair multiplier.
// Each byte is widened by one bit, either by sign or by zero extension, and
// the two widened values are multiplied as signed numbers. That covers every
// mix of signedness without overflow. Purely combinational.
module dot8_byte_mul #(
    parameter int BYTE_W = 8,
    localparam int EXT_W  = BYTE_W + 1,
    localparam int PROD_W = 2 * EXT_W
) (
    input  logic [BYTE_W-1:0]        a_byte,
    input  logic [BYTE_W-1:0]        b_byte,
    input  logic                     a_sgn,
    input  logic                     b_sgn,
    output logic signed [PROD_W-1:0] prod
);

    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;

    // Widen both bytes by one bit and form the exact signed product
    always_comb begin
        a_ext = {a_sgn & a_byte[BYTE_W-1], a_byte};
        b_ext = {b_sgn & b_byte[BYTE_W-1], b_byte};
        prod  = PROD_W'(a_ext) * PROD_W'(b_ext);
    end

endmodule

// File: rtl/dot8_lane.sv
// One accumulator lane.
// Forms LANE_W/BYTE_W byte products, sums them, and adds the sum to the
// accumulator lane at LANE_W+2 bits. The extra width keeps every sum exact.
// It then wraps the sum or clamps it to the signed or unsigned LANE_W range.
// Assumes LANE_W+2 exceeds the width of the product sum. Combinational.
module dot8_lane
    import dot8_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 32,
    localparam int NB     = LANE_W / BYTE_W,
    localparam int PROD_W = 2 * (BYTE_W + 1),
    localparam int SUM_W  = PROD_W + $clog2(NB) + 1,
    localparam int WIDE_W = LANE_W + 2
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  logic [LANE_W-1:0] acc_lane,
    input  dot_mode_e         mode,
    input  logic              sat_en,
    output logic [LANE_W-1:0] res_lane
);

    localparam logic signed [WIDE_W-1:0] ONE_W = 1;
    localparam logic signed [WIDE_W-1:0] SMAX  = (ONE_W <<< (LANE_W - 1)) - ONE_W;
    localparam logic signed [WIDE_W-1:0] SMIN  = -(ONE_W <<< (LANE_W - 1));
    localparam logic signed [WIDE_W-1:0] UMAX  = (ONE_W <<< LANE_W) - ONE_W;

    logic signed [PROD_W-1:0] prods [NB];
    logic signed [SUM_W-1:0]  dot_sum;
    logic signed [WIDE_W-1:0] acc_wide;
    logic signed [WIDE_W-1:0] total;
    logic                     a_sgn;
    logic                     b_sgn;
    logic                     acc_sgn;

    // Decode extension rules for this mode
    always_comb begin
        a_sgn   = first_signed(mode);
        b_sgn   = second_signed(mode);
        acc_sgn = acc_signed(mode);
    end

    // One multiplier per byte position; byte k pairs with byte k
    for (genvar k = 0; k < NB; k++) begin : g_mul
        dot8_byte_mul #(.BYTE_W(BYTE_W)) u_mul (
            .a_byte (a_lane[k*BYTE_W +: BYTE_W]),
            .b_byte (b_lane[k*BYTE_W +: BYTE_W]),
            .a_sgn  (a_sgn),
            .b_sgn  (b_sgn),
            .prod   (prods[k])
        );
    end

    // Sum the byte products with sign extension at full width
    always_comb begin
        dot_sum = '0;
        for (int k = 0; k < NB; k++) begin
            dot_sum = dot_sum + {{(SUM_W - PROD_W){prods[k][PROD_W-1]}}, prods[k]};
        end
    end

    // Exact accumulate: extend the accumulator by its signedness
    always_comb begin
        acc_wide = {{2{acc_sgn & acc_lane[LANE_W-1]}}, acc_lane};
        total    = acc_wide + {{(WIDE_W - SUM_W){dot_sum[SUM_W-1]}}, dot_sum};
    end

    // Wrap or clamp the exact sum into the lane
    always_comb begin
        res_lane = total[LANE_W-1:0];
        if (sat_en) begin
            if (acc_sgn) begin
                if (total > SMAX)      res_lane = SMAX[LANE_W-1:0];
                else if (total < SMIN) res_lane = SMIN[LANE_W-1:0];
            end else begin
                if (total > UMAX)      res_lane = UMAX[LANE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dot8_acc_unit.sv
// Packed byte dot-product accumulator, top level.
// Splits the vectors into LANES lanes of LANE_W bits and computes every lane
// in parallel. The result is registered with a one-cycle valid strobe.
// The result register is loaded only when in_valid is high.
// Synchronous active-low reset.
module dot8_acc_unit
    import dot8_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    input  logic [1:0]       mode,
    input  logic             sat_en,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);

    dot_mode_e        mode_e;
    logic [VEC_W-1:0] lane_res;

    // Map the raw mode code onto the typed enum
    always_comb mode_e = dot_mode_e'(mode);

    // Independent lanes
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        dot8_lane #(.BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_lane (
            .a_lane   (src_a [n*LANE_W +: LANE_W]),
            .b_lane   (src_b [n*LANE_W +: LANE_W]),
            .acc_lane (acc_in[n*LANE_W +: LANE_W]),
            .mode     (mode_e),
            .sat_en   (sat_en),
            .res_lane (lane_res[n*LANE_W +: LANE_W])
        );
    end

    // Output register: capture on in_valid, pulse out_valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= lane_res;
        end
    end

endmodule

// File: rtl/dot8_acc_unit_chk.sv
// Property checker for dot8_acc_unit, bound into every instance.
// Observes only ports.
module dot8_acc_unit_chk #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int VEC_W = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic [VEC_W-1:0] acc_in,
    input logic [1:0]       mode,
    input logic             sat_en,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);

    // R10: strobe follows the request by one cycle
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: result holds while idle
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && rst_n) |=> $stable(result));

    // R11: reset clears outputs
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R7: an all-zero first source adds nothing, so the accumulator passes unchanged
    p_zero_src_passes_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_a == '0) |=> result == $past(acc_in));

    // R9: saturating unsigned accumulate never drops below the accumulator
    for (genvar n = 0; n < LANES; n++) begin : g_uu
        p_uu_sat_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && sat_en && mode == 2'b00)
            |=> result[n*LANE_W +: LANE_W] >= $past(acc_in[n*LANE_W +: LANE_W]));
    end

endmodule

bind dot8_acc_unit dot8_acc_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .acc_in    (acc_in),
    .mode      (mode),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_dot8_acc_unit.sv
// Self-checking bench: byte sweeps in every mode and saturate setting, plus
// extreme-value corners. Expected results are computed arithmetically here.
module test_dot8_acc_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] acc_in = '0;
    logic [1:0]   mode = 2'b00;
    logic         sat_en = 1'b0;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    dot8_acc_unit i_dot8_acc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .mode(mode), .sat_en(sat_en),
        .out_valid(out_valid), .result(result)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired: actual cycles %0d expected < %0d", cycles, WATCHDOG);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic logic [31:0] next_rand(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Byte value under the R2 mode code: R3/R4/R5/R6 extension rules
    function automatic longint ext_byte(logic [7:0] v, bit sgn);
        return (sgn && v[7]) ? longint'(v) - 256 : longint'(v);
    endfunction

    // Reference lane: R1 pairing, R7 wrap, R8 signed clamp, R9 unsigned clamp
    function automatic logic [31:0] ref_lane(logic [31:0] a, logic [31:0] b,
                                             logic [31:0] acc, logic [1:0] m, bit sat);
        bit a_s, b_s, acc_s;
        longint s;
        a_s   = (m == 2'b10) || (m == 2'b11);
        b_s   = (m == 2'b10) || (m == 2'b01);
        acc_s = (m != 2'b00);
        s = acc_s ? longint'($signed(acc)) : longint'(acc);
        for (int k = 0; k < 4; k++)
            s += ext_byte(a[8*k +: 8], a_s) * ext_byte(b[8*k +: 8], b_s);
        if (sat) begin
            if (acc_s) begin
                if (s > 64'sd2147483647)  s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end else if (s > 64'sd4294967295) begin
                s = 64'sd4294967295;
            end
        end
        return s[31:0];
    endfunction

    function automatic string req_tag(logic [1:0] m, bit sat);
        if (sat) return (m == 2'b00) ? "R9" : "R8";
        case (m)
            2'b00:   return "R6";
            2'b01:   return "R5";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Apply one operation at a falling edge, check at the next falling edge (R10)
    task automatic run_op(logic [127:0] a, logic [127:0] b, logic [127:0] acc,
                          logic [1:0] m, bit sat);
        logic [127:0] exp_v;
        for (int n = 0; n < 4; n++)
            exp_v[32*n +: 32] = ref_lane(a[32*n +: 32], b[32*n +: 32], acc[32*n +: 32], m, sat);
        src_a = a; src_b = b; acc_in = acc; mode = m; sat_en = sat; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (result !== exp_v || out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL %s (R1 R2) mode=%0d sat=%0d a=%h b=%h acc=%h: actual %h/%0b expected %h/1",
                     req_tag(m, sat), m, sat, a, b, acc, result, out_valid, exp_v);
        end
    endtask

    initial begin
        logic [7:0]   bset [8];
        logic [7:0]   cset [2];
        logic [31:0]  aset [3];
        logic [127:0] va, vb, vacc, last;
        bset = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h55};
        cset = '{8'h80, 8'hFF};
        aset = '{32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

        // R11: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL R11 reset: actual %h/%0b expected 0/0", result, out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: every first-source byte against the partner set, rotated over positions
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int av = 0; av < 256; av++) begin
                    for (int bi = 0; bi < 8; bi++) begin
                        int lane, pos;
                        lane = av % 4;
                        pos  = (av / 4 + bi) % 4;
                        for (int n = 0; n < 4; n++) begin
                            lfsr = next_rand(lfsr); va[32*n +: 32] = lfsr;
                            lfsr = next_rand(lfsr); vb[32*n +: 32] = lfsr;
                            lfsr = next_rand(lfsr); vacc[32*n +: 32] = lfsr;
                        end
                        va[32*lane +: 32] = '0;
                        vb[32*lane +: 32] = '0;
                        va[32*lane + 8*pos +: 8] = 8'(av);
                        vb[32*lane + 8*pos +: 8] = bset[bi];
                        if (bi == 7) vacc[32*lane +: 32] = aset[av % 3];
                        run_op(va, vb, vacc, 2'(m), s[0]);
                    end
                end
            end
        end

        // Corners: all bytes 0x80 or 0xFF, accumulator at the range edges, R8/R9 clamp and R7 wrap
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int ai = 0; ai < 2; ai++)
                    for (int bi = 0; bi < 2; bi++)
                        for (int ci = 0; ci < 3; ci++)
                            run_op({16{cset[ai]}}, {16{cset[bi]}}, {4{aset[ci]}}, 2'(m), s[0]);

        // R10: an idle cycle keeps the result and drops the strobe
        last = result;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || result !== last) begin
            n_fail++;
            $display("FAIL R10 idle hold: actual %h/%0b expected %h/0", result, out_valid, last);
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule